// File: doc/BRIEF.md
# Output Compare Pulse Generator

This block is one output-compare channel. It takes the count values of two free-running timers and picks one of them as its time base. It compares that count against one or two compare values and drives a single output pin. A 4-bit control word sets the time base and the operating mode. The modes are:

- three single-match actions: set, clear or toggle the pin;
- a dual-match pulse that fires once or repeats;
- a pulse-width modulator, with or without a fault shutdown.

A compare event counts only on the first cycle the selected count equals the compare value. A time base that stalls on a value therefore triggers at most once. Every output is registered. An input seen in cycle k shows on the outputs after the clock edge that ends cycle k.

In the modulator modes, the first compare value works as a shadow duty register. The block copies it into a working duty register only at the selected timer's period-reset strobe and when the mode is entered. This means software can change the duty cycle at any time without producing a glitch in the current period. In the protected modulator mode, a low level on the fault input forces the pin low at once and latches a status flag. Only a change of the mode field releases the flag.

Top module: `ocmp_pulse_gen`

## Requirements
- R1: Control bit 3 selects the time base: 0 uses `tmr_a` with `prd_a`, 1 uses `tmr_b` with `prd_b`. A match on the unselected timer has no effect on the outputs.
- R2: Control bits 2:0 select the mode: 0 off, 1 set-on-match, 2 clear-on-match, 3 toggle-on-match, 4 dual one-shot, 5 dual continuous, 6 modulator, 7 modulator with fault shutdown. In mode 0 the pin is low.
- R3: In modes 1, 2 and 3, a compare event on `cmp_pri` drives the pin high (mode 1), drives it low (mode 2) or inverts it (mode 3). Each such event also gives an interrupt pulse.
- R4: A compare event occurs only in the first cycle of an equality run. A time base held at the compare value does not trigger again.
- R5: In mode 4, the pin rises on a `cmp_pri` event and falls on a `cmp_sec` event. After that fall it stays low through later events until the mode field changes.
- R6: In mode 5, the pin rises on a `cmp_pri` event and falls on a `cmp_sec` event, and this repeats for every period.
- R7: In modes 6 and 7:
  - The pin goes high on the selected period-reset strobe.
  - The pin goes low on an event against the working duty value.
  - The working duty value loads from `cmp_pri` only at the strobe or at mode entry. A change to `cmp_pri` in mid-period does not affect the current period.
- R8: In mode 7, `fault_n` sampled low forces the pin low and sets `fault_flag`. While the flag is set the pin stays low, including at period strobes. Only a change of the mode field clears the flag. In mode 6, `fault_n` is ignored.
- R9: `oc_irq` is a one-cycle pulse. It fires on the acting event in modes 1 to 3, on the falling `cmp_sec` event in modes 4 and 5, and on an unfaulted period strobe in modes 6 and 7. It never fires in mode 0.
- R10: Synchronous reset clears `oc_pin`, `oc_irq` and `fault_flag`, and returns the mode register to off.
- R11: In a cycle where the mode field changes, compare events are ignored. The pin takes the entry level of the new mode on the next edge: high for mode 2, low for every other mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_a | input | 16 | Count of time base A |
| tmr_b | input | 16 | Count of time base B |
| prd_a | input | 1 | Period-reset strobe of time base A |
| prd_b | input | 1 | Period-reset strobe of time base B |
| cmp_pri | input | 16 | Primary compare value, duty shadow in modulator modes |
| cmp_sec | input | 16 | Secondary compare value for dual modes |
| ctrl | input | 4 | Bit 3 time-base select, bits 2:0 mode |
| fault_n | input | 1 | Active-low fault input |
| oc_pin | output | 1 | Compare output pin |
| oc_irq | output | 1 | Compare interrupt pulse |
| fault_flag | output | 1 | Latched fault status |

## Verification
The bench holds a timer on the compare value for several cycles. A design that compared levels instead of detecting events would toggle or interrupt again during the stall. It presents a match on the unselected timer, which a wrong multiplexer would act on. It revisits the one-shot compare values after the pulse; a missing one-shot latch would produce a second pulse. It rewrites the duty shadow in mid-period, which an unshadowed duty would apply at once. It asserts the fault together with a period strobe and then strobes again with the fault removed. A latch that released by itself, or a strobe that took priority over the fault, would drive the pin high. It also changes the mode while the timer already sits on the compare value, which a design without mode-change priority would treat as an event.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  localparam int CTRL_W   = 4;
  localparam int MODE_W   = 3;
  localparam int TSEL_BIT = 3;

  typedef enum logic [MODE_W-1:0] {
    OCM_OFF      = 3'd0,
    OCM_SET_HI   = 3'd1,
    OCM_SET_LO   = 3'd2,
    OCM_TOGGLE   = 3'd3,
    OCM_DUAL_ONE = 3'd4,
    OCM_DUAL_RUN = 3'd5,
    OCM_PWM      = 3'd6,
    OCM_PWM_FLT  = 3'd7
  } ocm_mode_e;

  function automatic logic mode_is_pwm(input ocm_mode_e m);
    return (m == OCM_PWM) || (m == OCM_PWM_FLT);
  endfunction

  function automatic logic mode_is_dual(input ocm_mode_e m);
    return (m == OCM_DUAL_ONE) || (m == OCM_DUAL_RUN);
  endfunction

  // Pin level taken on entry to a mode (R11).
  function automatic logic mode_entry_level(input ocm_mode_e m);
    return (m == OCM_SET_LO);
  endfunction

endpackage

// File: rtl/ocmp_tbase_sel.sv
module ocmp_tbase_sel #(
  parameter int W    = 16,
  parameter int N_TB = 2,
  localparam int SEL_W = (N_TB > 1) ? $clog2(N_TB) : 1
) (
  input  logic [N_TB-1:0][W-1:0] tmr_in,
  input  logic [N_TB-1:0]        prd_in,
  input  logic [SEL_W-1:0]       sel,
  output logic [W-1:0]           tmr_out,
  output logic                   prd_out
);

  always_comb begin
    tmr_out = '0;
    prd_out = 1'b0;
    for (int i = 0; i < N_TB; i++) begin
      if (sel == SEL_W'(i)) begin
        tmr_out = tmr_in[i];
        prd_out = prd_in[i];
      end
    end
  end

endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int W     = 16,
  parameter int N_REF = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [W-1:0]            tmr,
  input  logic [N_REF-1:0][W-1:0] ref_val,
  output logic [N_REF-1:0]        hit
);

  genvar g;
  generate
    for (g = 0; g < N_REF; g++) begin : g_cmp
      logic eq_now;
      logic eq_q;
      assign eq_now = (tmr == ref_val[g]);
      always_ff @(posedge clk) begin
        if (rst) eq_q <= 1'b0;
        else     eq_q <= eq_now;
      end
      // Event only on the first cycle of equality.
      assign hit[g] = eq_now & ~eq_q;
    end
  endgenerate

endmodule

// File: rtl/ocmp_duty_shadow.sv
module ocmp_duty_shadow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] shadow,
  output logic [W-1:0] duty
);

  always_ff @(posedge clk) begin
    if (rst)       duty <= '0;
    else if (load) duty <= shadow;
  end

endmodule

// File: rtl/ocmp_fault_latch.sv
module ocmp_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic clear,
  input  logic fault_n,
  output logic trip,
  output logic flag
);

  assign trip = arm & ~fault_n;

  always_ff @(posedge clk) begin
    if (rst)        flag <= 1'b0;
    else if (clear) flag <= 1'b0;
    else if (trip)  flag <= 1'b1;
  end

endmodule

// File: rtl/ocmp_pulse_gen.sv
module ocmp_pulse_gen
  import ocmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      tmr_a,
  input  logic [W-1:0]      tmr_b,
  input  logic              prd_a,
  input  logic              prd_b,
  input  logic [W-1:0]      cmp_pri,
  input  logic [W-1:0]      cmp_sec,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              fault_n,
  output logic              oc_pin,
  output logic              oc_irq,
  output logic              fault_flag
);

  localparam int N_TB  = 2;
  localparam int N_REF = 2;
  localparam int REF_PRI = 0;
  localparam int REF_SEC = 1;

  ocm_mode_e mode, mode_q;
  logic      mode_chg;
  logic      pwm_sel;

  assign mode     = ocm_mode_e'(ctrl[MODE_W-1:0]);
  assign mode_chg = (mode != mode_q);
  assign pwm_sel  = mode_is_pwm(mode);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= OCM_OFF;
    else     mode_q <= mode;
  end

  // Time base selection
  logic [W-1:0] tb_cnt;
  logic         tb_prd;

  ocmp_tbase_sel #(.W(W), .N_TB(N_TB)) u_tbase (
    .tmr_in  ({tmr_b, tmr_a}),
    .prd_in  ({prd_b, prd_a}),
    .sel     (ctrl[TSEL_BIT]),
    .tmr_out (tb_cnt),
    .prd_out (tb_prd)
  );

  // Working duty register
  logic [W-1:0] duty_q;
  logic         duty_load;

  assign duty_load = mode_chg | (pwm_sel & tb_prd);

  ocmp_duty_shadow #(.W(W)) u_duty (
    .clk    (clk),
    .rst    (rst),
    .load   (duty_load),
    .shadow (cmp_pri),
    .duty   (duty_q)
  );

  // Compare events
  logic [N_REF-1:0][W-1:0] refs;
  logic [N_REF-1:0]        hit;

  always_comb begin
    refs[REF_PRI] = cmp_pri;
    refs[REF_SEC] = pwm_sel ? duty_q : cmp_sec;
  end

  ocmp_match #(.W(W), .N_REF(N_REF)) u_match (
    .clk     (clk),
    .rst     (rst),
    .tmr     (tb_cnt),
    .ref_val (refs),
    .hit     (hit)
  );

  // Fault shutdown
  logic trip;
  logic flt_arm;

  assign flt_arm = (mode == OCM_PWM_FLT) & ~mode_chg;

  ocmp_fault_latch u_fault (
    .clk     (clk),
    .rst     (rst),
    .arm     (flt_arm),
    .clear   (mode_chg),
    .fault_n (fault_n),
    .trip    (trip),
    .flag    (fault_flag)
  );

  // Pin sequencing
  logic pin_q, pin_d;
  logic irq_q, irq_d;
  logic done_q, done_d;

  always_comb begin
    pin_d  = pin_q;
    irq_d  = 1'b0;
    done_d = done_q;
    if (mode_chg) begin
      pin_d  = mode_entry_level(mode);
      done_d = 1'b0;
    end else begin
      unique case (mode)
        OCM_OFF: pin_d = 1'b0;
        OCM_SET_HI: begin
          if (hit[REF_PRI]) begin
            pin_d = 1'b1;
            irq_d = 1'b1;
          end
        end
        OCM_SET_LO: begin
          if (hit[REF_PRI]) begin
            pin_d = 1'b0;
            irq_d = 1'b1;
          end
        end
        OCM_TOGGLE: begin
          if (hit[REF_PRI]) begin
            pin_d = ~pin_q;
            irq_d = 1'b1;
          end
        end
        OCM_DUAL_ONE, OCM_DUAL_RUN: begin
          if (pin_q && hit[REF_SEC]) begin
            pin_d = 1'b0;
            irq_d = 1'b1;
            if (mode == OCM_DUAL_ONE) done_d = 1'b1;
          end else if (!pin_q && hit[REF_PRI] && !done_q) begin
            pin_d = 1'b1;
          end
        end
        OCM_PWM, OCM_PWM_FLT: begin
          if (trip || fault_flag) begin
            pin_d = 1'b0;
          end else if (tb_prd) begin
            pin_d = 1'b1;
            irq_d = 1'b1;
          end else if (hit[REF_SEC]) begin
            pin_d = 1'b0;
          end
        end
        default: pin_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      irq_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pin_q  <= pin_d;
      irq_q  <= irq_d;
      done_q <= done_d;
    end
  end

  assign oc_pin = pin_q;
  assign oc_irq = irq_q;

endmodule

// File: rtl/ocmp_pulse_gen_chk.sv
module ocmp_pulse_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] ctrl,
  input logic       fault_n,
  input logic       oc_pin,
  input logic       oc_irq,
  input logic       fault_flag
);

  // Edges since reset, so history-based checks never look back past reset.
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)             age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_fault_forces_low_r8: assert property (@(posedge clk) disable iff (rst)
    fault_flag |-> !oc_pin);

  p_flag_source_r8: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && $rose(fault_flag)) |-> ($past(ctrl[2:0]) == 3'd7 && !$past(fault_n)));

  p_flag_release_r8: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $fell(fault_flag)) |-> ($past(ctrl[2:0]) != $past(ctrl[2:0], 2)));

  p_off_low_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl[2:0] == 3'd0) |=> !oc_pin);

  p_irq_needs_mode_r9: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && oc_irq) |-> ($past(ctrl[2:0]) != 3'd0));

  p_setlo_no_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $rose(oc_pin)) |-> !($past(ctrl[2:0]) == 3'd2 && $past(ctrl[2:0], 2) == 3'd2));

  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd1) |-> (!oc_pin && !oc_irq && !fault_flag));

endmodule

bind ocmp_pulse_gen ocmp_pulse_gen_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctrl       (ctrl),
  .fault_n    (fault_n),
  .oc_pin     (oc_pin),
  .oc_irq     (oc_irq),
  .fault_flag (fault_flag)
);

// File: tb/ocmp_pulse_gen_tb.sv
module ocmp_pulse_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tmr_a = '0, tmr_b = '0, cmp_pri = '0, cmp_sec = '0;
  logic        prd_a = 1'b0, prd_b = 1'b0, fault_n = 1'b1;
  logic [3:0]  ctrl = '0;
  logic        oc_pin, oc_irq, fault_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ocmp_pulse_gen u_dut (
    .clk(clk), .rst(rst), .tmr_a(tmr_a), .tmr_b(tmr_b),
    .prd_a(prd_a), .prd_b(prd_b), .cmp_pri(cmp_pri), .cmp_sec(cmp_sec),
    .ctrl(ctrl), .fault_n(fault_n),
    .oc_pin(oc_pin), .oc_irq(oc_irq), .fault_flag(fault_flag)
  );

  typedef struct packed {
    logic [3:0]  c;
    logic [15:0] ta;
    logic [15:0] tb;
    logic        pa;
    logic        pb;
    logic [15:0] cp;
    logic [15:0] cs;
    logic        fn;
    logic [2:0]  exp;   // {pin, irq, flag}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t TBL [NV] = '{
    // R3 set-high, R4 stall
    '{4'h1, 16'd5,  16'd0,  1'b0, 1'b0, 16'd10, 16'd0, 1'b1, 3'b000, 4'd11},
    '{4'h1, 16'd10, 16'd0,  1'b0, 1'b0, 16'd10, 16'd0, 1'b1, 3'b110, 4'd3},
    '{4'h1, 16'd10, 16'd0,  1'b0, 1'b0, 16'd10, 16'd0, 1'b1, 3'b100, 4'd4},
    '{4'h1, 16'd11, 16'd0,  1'b0, 1'b0, 16'd10, 16'd0, 1'b1, 3'b100, 4'd3},
    // R11 entry high, R3 clear-on-match
    '{4'h2, 16'd12, 16'd0,  1'b0, 1'b0, 16'd10, 16'd0, 1'b1, 3'b100, 4'd11},
    '{4'h2, 16'd10, 16'd0,  1'b0, 1'b0, 16'd10, 16'd0, 1'b1, 3'b010, 4'd3},
    // R3 toggle
    '{4'h3, 16'd11, 16'd0,  1'b0, 1'b0, 16'd10, 16'd0, 1'b1, 3'b000, 4'd11},
    '{4'h3, 16'd10, 16'd0,  1'b0, 1'b0, 16'd10, 16'd0, 1'b1, 3'b110, 4'd3},
    '{4'h3, 16'd11, 16'd0,  1'b0, 1'b0, 16'd10, 16'd0, 1'b1, 3'b100, 4'd3},
    '{4'h3, 16'd10, 16'd0,  1'b0, 1'b0, 16'd10, 16'd0, 1'b1, 3'b010, 4'd3},
    // R1 time-base B
    '{4'hB, 16'd0,  16'd7,  1'b0, 1'b0, 16'd10, 16'd0, 1'b1, 3'b000, 4'd1},
    '{4'hB, 16'd10, 16'd3,  1'b0, 1'b0, 16'd10, 16'd0, 1'b1, 3'b000, 4'd1},
    '{4'hB, 16'd0,  16'd10, 1'b0, 1'b0, 16'd10, 16'd0, 1'b1, 3'b110, 4'd1},
    // R5 dual one-shot
    '{4'hC, 16'd0,  16'd0,  1'b0, 1'b0, 16'd4,  16'd8, 1'b1, 3'b000, 4'd11},
    '{4'hC, 16'd0,  16'd4,  1'b0, 1'b0, 16'd4,  16'd8, 1'b1, 3'b100, 4'd5},
    '{4'hC, 16'd0,  16'd8,  1'b0, 1'b0, 16'd4,  16'd8, 1'b1, 3'b010, 4'd5},
    '{4'hC, 16'd0,  16'd0,  1'b0, 1'b0, 16'd4,  16'd8, 1'b1, 3'b000, 4'd5},
    '{4'hC, 16'd0,  16'd4,  1'b0, 1'b0, 16'd4,  16'd8, 1'b1, 3'b000, 4'd5},
    '{4'hC, 16'd0,  16'd8,  1'b0, 1'b0, 16'd4,  16'd8, 1'b1, 3'b000, 4'd5},
    // R6 dual continuous
    '{4'hD, 16'd0,  16'd0,  1'b0, 1'b0, 16'd4,  16'd8, 1'b1, 3'b000, 4'd11},
    '{4'hD, 16'd0,  16'd4,  1'b0, 1'b0, 16'd4,  16'd8, 1'b1, 3'b100, 4'd6},
    '{4'hD, 16'd0,  16'd8,  1'b0, 1'b0, 16'd4,  16'd8, 1'b1, 3'b010, 4'd6},
    '{4'hD, 16'd0,  16'd4,  1'b0, 1'b0, 16'd4,  16'd8, 1'b1, 3'b100, 4'd6},
    '{4'hD, 16'd0,  16'd8,  1'b0, 1'b0, 16'd4,  16'd8, 1'b1, 3'b010, 4'd6},
    // R7 modulator with shadowed duty
    '{4'h6, 16'd0,  16'd0,  1'b0, 1'b0, 16'd3,  16'd0, 1'b1, 3'b000, 4'd11},
    '{4'h6, 16'd0,  16'd0,  1'b1, 1'b0, 16'd3,  16'd0, 1'b1, 3'b110, 4'd7},
    '{4'h6, 16'd1,  16'd0,  1'b0, 1'b0, 16'd6,  16'd0, 1'b1, 3'b100, 4'd7},
    '{4'h6, 16'd3,  16'd0,  1'b0, 1'b0, 16'd6,  16'd0, 1'b1, 3'b000, 4'd7},
    '{4'h6, 16'd4,  16'd0,  1'b0, 1'b0, 16'd6,  16'd0, 1'b1, 3'b000, 4'd7},
    '{4'h6, 16'd0,  16'd0,  1'b1, 1'b0, 16'd6,  16'd0, 1'b1, 3'b110, 4'd7},
    '{4'h6, 16'd3,  16'd0,  1'b0, 1'b0, 16'd6,  16'd0, 1'b1, 3'b100, 4'd7},
    '{4'h6, 16'd6,  16'd0,  1'b0, 1'b0, 16'd6,  16'd0, 1'b1, 3'b000, 4'd7},
    // R8 fault ignored in mode 6, then latched in mode 7
    '{4'h6, 16'd0,  16'd0,  1'b1, 1'b0, 16'd6,  16'd0, 1'b0, 3'b110, 4'd8},
    '{4'h7, 16'd1,  16'd0,  1'b0, 1'b0, 16'd6,  16'd0, 1'b1, 3'b000, 4'd11},
    '{4'h7, 16'd0,  16'd0,  1'b1, 1'b0, 16'd6,  16'd0, 1'b1, 3'b110, 4'd9},
    '{4'h7, 16'd2,  16'd0,  1'b0, 1'b0, 16'd6,  16'd0, 1'b0, 3'b001, 4'd8},
    '{4'h7, 16'd0,  16'd0,  1'b1, 1'b0, 16'd6,  16'd0, 1'b1, 3'b001, 4'd8},
    '{4'h6, 16'd1,  16'd0,  1'b0, 1'b0, 16'd6,  16'd0, 1'b1, 3'b000, 4'd8},
    '{4'h6, 16'd0,  16'd0,  1'b1, 1'b0, 16'd6,  16'd0, 1'b1, 3'b110, 4'd9},
    // R2 off
    '{4'h0, 16'd0,  16'd0,  1'b0, 1'b0, 16'd6,  16'd0, 1'b1, 3'b000, 4'd2}
  };

  task automatic chk(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {oc_pin, oc_irq, fault_flag};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pin/irq/flag actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [3:0] c, input logic [15:0] ta, input logic [15:0] tb,
                     input logic pa, input logic pb, input logic [15:0] cp,
                     input logic [15:0] cs, input logic fn);
    @(negedge clk);
    ctrl = c; tmr_a = ta; tmr_b = tb; prd_a = pa; prd_b = pb;
    cmp_pri = cp; cmp_sec = cs; fault_n = fn;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10 reset state", 3'b000);

    for (int i = 0; i < NV; i++) begin
      string tag;
      cyc(TBL[i].c, TBL[i].ta, TBL[i].tb, TBL[i].pa, TBL[i].pb,
          TBL[i].cp, TBL[i].cs, TBL[i].fn);
      tag = $sformatf("R%0d vector %0d", TBL[i].req, i);
      chk(tag, TBL[i].exp);
    end

    // R11: mode entry while the timer already equals the compare value
    cyc(4'h1, 16'd10, 16'd0, 1'b0, 1'b0, 16'd10, 16'd0, 1'b1);
    chk("R11 entry ignores match", 3'b000);
    cyc(4'h1, 16'd10, 16'd0, 1'b0, 1'b0, 16'd10, 16'd0, 1'b1);
    chk("R4 held equality after entry", 3'b000);
    cyc(4'h1, 16'd9, 16'd0, 1'b0, 1'b0, 16'd10, 16'd0, 1'b1);
    chk("R3 no match", 3'b000);
    cyc(4'h1, 16'd10, 16'd0, 1'b0, 1'b0, 16'd10, 16'd0, 1'b1);
    chk("R3 set on fresh match", 3'b110);

    // R8: fault together with a period strobe
    cyc(4'h7, 16'd1, 16'd0, 1'b0, 1'b0, 16'd5, 16'd0, 1'b1);
    chk("R11 entry to mode 7", 3'b000);
    cyc(4'h7, 16'd0, 16'd0, 1'b1, 1'b0, 16'd5, 16'd0, 1'b0);
    chk("R8 fault beats strobe", 3'b001);
    cyc(4'h7, 16'd0, 16'd0, 1'b1, 1'b0, 16'd5, 16'd0, 1'b1);
    chk("R8 flag held after fault clears", 3'b001);
    cyc(4'h6, 16'd1, 16'd0, 1'b0, 1'b0, 16'd5, 16'd0, 1'b1);
    chk("R8 mode change releases flag", 3'b000);
    cyc(4'h6, 16'd0, 16'd0, 1'b1, 1'b0, 16'd5, 16'd0, 1'b1);
    chk("R7 strobe after release", 3'b110);

    // R10: reset in mid-run with the pin high
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R10 reset clears outputs", 3'b000);
    @(negedge clk);
    rst = 1'b0;
    ctrl = 4'h0;
    @(posedge clk);
    #1;
    chk("R2 off after reset", 3'b000);

    finished = 1'b1;
    finish_run();
  end

endmodule